// File: doc/BRIEF.md
# I2C Pooled Byte Transfer Engine

This block moves runs of bytes between a small byte-addressed pool memory and the byte-level link of one I2C channel. Software first fills the pool through a byte-lane access port and programs a pool control word. That word holds a window offset, a transmit length, a receive length and a receive tally that only the hardware writes. It then issues a command. For a transmit, the engine reads pool bytes and hands them one at a time to the byte link. When the command also asks for a start, the first pool byte is the address byte. For a receive, the engine stores incoming bytes from the start of the window and records how many it stored.

Both lengths are held as value minus one, so the 8-bit fields cover 1 to 256 bytes. In paged addressing the window base moves in 256-byte steps chosen by a 3-bit page number. Any command that asks for pool or memory-transfer help is refused outright while the global memory enable is low. When the whole sequence ends, the engine gives the command sequencer a one-cycle completion pulse with a pass/fail flag.

Top module: `i2c_pool_engine`

## Requirements
- R1: After reset the pool control word reads 0. A software write to it replaces bits 23:0 and leaves bits 31:24 unchanged. Bits 31:24 change only when a buffered receive completes.
- R2: The CPU port reads and writes 1 to 4 bytes per access (cpu_size_i = byte count minus one), little-endian: lane k sits in data bits 8k+7:8k and maps to pool index addr+k modulo the pool size. Read data appears on cpu_rdata_o the cycle after the request, and lanes past the count read as zero.
- R3: The window base is offset×4, where the offset is in control bits 5:0. With page_mode_i high, page_i×256 is added to it. Every pool index used by a transfer is (base + i) modulo POOL_BYTES, and POOL_BYTES is a power of two.
- R4: The cmd_i bits are start [0], tx [1], rx [2], last [3], tx_buf [4], rx_buf [5], tx_dma [6] and rx_dma [7]. With start and tx_buf, window byte 0 goes out with link_start_o high. When tx is also set and the transmit field (bits 15:8) is non-zero, window bytes 1 up to that field value follow. Otherwise no data bytes follow.
- R5: With tx and tx_buf and no start, window bytes 0 up to the transmit field value are sent in order, with link_start_o low.
- R6: Transmission ends at the first byte whose link_ack_i is low. No further bytes are sent, and the receive phase is skipped.
- R7: With rx and rx_buf, and no earlier refusal by the slave, the engine receives (receive field, bits 23:16) + 1 bytes into window indices 0 upward. It then writes that count modulo 256 into bits 31:24. link_last_o is high on the final byte only when last is set.
- R8: The two bits of buf_en_o (bit 0 transmit, bit 1 receive) are set from tx_buf/rx_buf when a command is accepted. Each clears when its phase ends, and both are clear after the completion pulse.
- R9: While sram_en_i is low, a command with any of bits 7:4 set is refused. The engine stays idle, makes no link request and gives no completion pulse.
- R10: Every accepted command ends with done_o high for exactly one cycle. done_ack_o is high in that cycle only if no sent byte was refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sram_en_i | input | 1 | Global pool/memory enable |
| page_mode_i | input | 1 | Selects paged window addressing |
| page_i | input | 3 | Page number for paged addressing |
| pctl_we_i | input | 1 | Software write strobe for the control word |
| pctl_wdata_i | input | 32 | Control word write data |
| pctl_o | output | 32 | Current control word |
| cpu_req_i | input | 1 | CPU pool access request |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | AW | CPU byte address into the pool |
| cpu_size_i | input | 2 | Bytes in the access minus one |
| cpu_wdata_i | input | 32 | CPU write data, lane 0 in bits 7:0 |
| cpu_rdata_o | output | 32 | CPU read data, valid the cycle after a read |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command bits as listed in R4 |
| busy_o | output | 1 | Engine is running a command |
| buf_en_o | output | 2 | Buffered transmit/receive enables in flight |
| done_o | output | 1 | One-cycle completion pulse |
| done_ack_o | output | 1 | All sent bytes were acknowledged |
| link_req_o | output | 1 | Byte request to the link, held until done |
| link_start_o | output | 1 | Byte is the address byte after a start |
| link_op_o | output | 1 | 0 send, 1 receive |
| link_last_o | output | 1 | Receive byte is the last (answer with NAK) |
| link_data_o | output | 8 | Byte to send |
| link_done_i | input | 1 | Link finished the current byte |
| link_ack_i | input | 1 | Slave acknowledged the sent byte |
| link_data_i | input | 8 | Received byte |

## Verification
The assertions assume that the byte link keeps link_done_i low while no request is up, raises it for one cycle per request, and presents link_ack_i and link_data_i with it. The bench's link model waits for a request, holds off a random 0 to 2 cycles, then pulses done exactly once before it looks for the next request. The assertions also assume commands arrive only while the engine is idle. The bench issues each command and then waits for the completion pulse before it changes the control word or the page inputs.

// File: rtl/i2c_pool_pkg.sv
package i2c_pool_pkg;

  // command word, bit 0 is start
  typedef struct packed {
    logic rx_dma;
    logic tx_dma;
    logic rx_buf;
    logic tx_buf;
    logic last;
    logic rx;
    logic tx;
    logic start;
  } xfer_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TX,
    ST_RX,
    ST_DONE
  } eng_state_e;

  localparam int CNT_W = 8;
  localparam int OFF_W = 6;

endpackage

// File: rtl/ipool_ram.sv
module ipool_ram #(
  parameter int  POOL_BYTES = 256,
  localparam int AW         = $clog2(POOL_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic [31:0]   cpu_rdata_o,
  input  logic [AW-1:0] eng_addr_i,
  output logic [7:0]    eng_rdata_o,
  input  logic          eng_we_i,
  input  logic [7:0]    eng_wdata_i
);

  localparam int LANES = 4;

  logic [7:0]    mem_q [POOL_BYTES];
  logic [AW-1:0] lane_addr [LANES];
  logic [LANES-1:0] lane_en;
  logic [31:0]   rdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = cpu_addr_i + AW'(g);
    assign lane_en[g]   = (2'(g) <= cpu_size_i);
  end

  // engine write placed last so it wins a same-byte collision
  always_ff @(posedge clk_i) begin
    if (cpu_req_i && cpu_we_i) begin
      for (int b = 0; b < LANES; b++) begin
        if (lane_en[b]) mem_q[lane_addr[b]] <= cpu_wdata_i[8*b +: 8];
      end
    end
    if (eng_we_i) mem_q[eng_addr_i] <= eng_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (cpu_req_i && !cpu_we_i) begin
      for (int b = 0; b < LANES; b++) begin
        rdata_q[8*b +: 8] <= lane_en[b] ? mem_q[lane_addr[b]] : 8'h00;
      end
    end
  end

  assign cpu_rdata_o = rdata_q;
  assign eng_rdata_o = mem_q[eng_addr_i];

endmodule

// File: rtl/ipool_ctl.sv
module ipool_ctl
  import i2c_pool_pkg::*;
#(
  parameter int  POOL_BYTES = 256,
  localparam int AW         = $clog2(POOL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [31:0]      sw_wdata_i,
  input  logic             hw_we_i,
  input  logic [CNT_W-1:0] hw_cnt_i,
  input  logic             page_mode_i,
  input  logic [2:0]       page_i,
  output logic [31:0]      pctl_o,
  output logic [AW-1:0]    base_o,
  output logic [CNT_W-1:0] tx_last_o,
  output logic [CNT_W-1:0] rx_last_o
);

  localparam int FW = (AW > 11) ? AW : 11;

  logic [23:0]      sw_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-1:0]    page_base;
  logic [FW-1:0]    full_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (sw_we_i) sw_q  <= sw_wdata_i[23:0];
      if (hw_we_i) cnt_q <= hw_cnt_i;
    end
  end

  assign page_base = page_mode_i ? (FW'(page_i) << 8) : '0;
  assign full_base = page_base + (FW'(sw_q[OFF_W-1:0]) << 2);

  assign base_o    = full_base[AW-1:0];
  assign tx_last_o = sw_q[15:8];
  assign rx_last_o = sw_q[23:16];
  assign pctl_o    = {cnt_q, sw_q};

endmodule

// File: rtl/ipool_seq.sv
module ipool_seq
  import i2c_pool_pkg::*;
#(
  parameter int  POOL_BYTES = 256,
  localparam int AW         = $clog2(POOL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  xfer_cmd_t        cmd_i,
  input  logic             sram_en_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] tx_last_i,
  input  logic [CNT_W-1:0] rx_last_i,
  input  logic [7:0]       pool_rdata_i,
  output logic [AW-1:0]    pool_addr_o,
  output logic             pool_we_o,
  output logic [7:0]       pool_wdata_o,
  output logic             cnt_we_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             link_req_o,
  output logic             link_start_o,
  output logic             link_op_o,
  output logic             link_last_o,
  output logic [7:0]       link_data_o,
  input  logic             link_done_i,
  input  logic             link_ack_i,
  input  logic [7:0]       link_data_i,
  output logic             busy_o,
  output logic [1:0]       buf_en_o,
  output logic             done_o,
  output logic             done_ack_o
);

  eng_state_e       state_q;
  logic [CNT_W-1:0] idx_q, txl_q, rxl_q;
  logic [AW-1:0]    base_q;
  logic             tx_q, rxp_q, last_q, nak_q;
  logic [1:0]       buf_q;

  logic uses_mem, gated, go_addr, go_tx, go_rx, accept;
  logic rx_final;

  assign uses_mem = cmd_i.tx_buf | cmd_i.rx_buf | cmd_i.tx_dma | cmd_i.rx_dma;
  assign gated    = uses_mem & ~sram_en_i;
  assign go_addr  = cmd_i.start & cmd_i.tx_buf;
  assign go_tx    = cmd_i.tx & cmd_i.tx_buf;
  assign go_rx    = cmd_i.rx & cmd_i.rx_buf;
  assign accept   = cmd_valid_i && (state_q == ST_IDLE) && !gated &&
                    (go_addr || go_tx || go_rx);
  assign rx_final = (idx_q == rxl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      txl_q   <= '0;
      rxl_q   <= '0;
      base_q  <= '0;
      tx_q    <= 1'b0;
      rxp_q   <= 1'b0;
      last_q  <= 1'b0;
      nak_q   <= 1'b0;
      buf_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            base_q <= base_i;
            txl_q  <= tx_last_i;
            rxl_q  <= rx_last_i;
            tx_q   <= cmd_i.tx;
            rxp_q  <= go_rx;
            last_q <= cmd_i.last;
            nak_q  <= 1'b0;
            idx_q  <= '0;
            buf_q  <= {cmd_i.rx_buf, cmd_i.tx_buf};
            state_q <= go_addr ? ST_ADDR : (go_tx ? ST_TX : ST_RX);
          end
        end
        ST_ADDR: begin
          if (link_done_i) begin
            if (!link_ack_i) begin
              nak_q    <= 1'b1;
              buf_q[0] <= 1'b0;
              state_q  <= ST_DONE;
            end else if (tx_q && (txl_q != '0)) begin
              idx_q   <= CNT_W'(1);
              state_q <= ST_TX;
            end else begin
              buf_q[0] <= 1'b0;
              idx_q    <= '0;
              state_q  <= rxp_q ? ST_RX : ST_DONE;
            end
          end
        end
        ST_TX: begin
          if (link_done_i) begin
            if (!link_ack_i) begin
              nak_q    <= 1'b1;
              buf_q[0] <= 1'b0;
              state_q  <= ST_DONE;
            end else if (idx_q == txl_q) begin
              buf_q[0] <= 1'b0;
              idx_q    <= '0;
              state_q  <= rxp_q ? ST_RX : ST_DONE;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        ST_RX: begin
          if (link_done_i) begin
            if (rx_final) begin
              buf_q[1] <= 1'b0;
              state_q  <= ST_DONE;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        ST_DONE: begin
          buf_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pool_addr_o  = base_q + AW'(idx_q);
  assign pool_we_o    = (state_q == ST_RX) && link_done_i;
  assign pool_wdata_o = link_data_i;
  assign cnt_we_o     = pool_we_o && rx_final;
  assign cnt_o        = rxl_q + CNT_W'(1);

  assign link_req_o   = (state_q == ST_ADDR) || (state_q == ST_TX) || (state_q == ST_RX);
  assign link_start_o = (state_q == ST_ADDR);
  assign link_op_o    = (state_q == ST_RX);
  assign link_last_o  = (state_q == ST_RX) && last_q && rx_final;
  assign link_data_o  = pool_rdata_i;

  assign busy_o     = (state_q != ST_IDLE);
  assign buf_en_o   = buf_q;
  assign done_o     = (state_q == ST_DONE);
  assign done_ack_o = (state_q == ST_DONE) && !nak_q;

endmodule

// File: rtl/i2c_pool_engine.sv
module i2c_pool_engine
  import i2c_pool_pkg::*;
#(
  parameter int  POOL_BYTES = 256,
  localparam int AW         = $clog2(POOL_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sram_en_i,
  input  logic          page_mode_i,
  input  logic [2:0]    page_i,
  input  logic          pctl_we_i,
  input  logic [31:0]   pctl_wdata_i,
  output logic [31:0]   pctl_o,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [1:0]    cpu_size_i,
  input  logic [31:0]   cpu_wdata_i,
  output logic [31:0]   cpu_rdata_o,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_i,
  output logic          busy_o,
  output logic [1:0]    buf_en_o,
  output logic          done_o,
  output logic          done_ack_o,
  output logic          link_req_o,
  output logic          link_start_o,
  output logic          link_op_o,
  output logic          link_last_o,
  output logic [7:0]    link_data_o,
  input  logic          link_done_i,
  input  logic          link_ack_i,
  input  logic [7:0]    link_data_i
);

  logic [AW-1:0]    base;
  logic [CNT_W-1:0] tx_last, rx_last, cnt;
  logic             cnt_we;
  logic [AW-1:0]    pool_addr;
  logic [7:0]       pool_rdata, pool_wdata;
  logic             pool_we;
  xfer_cmd_t        cmd;

  assign cmd = xfer_cmd_t'(cmd_i);

  ipool_ctl #(.POOL_BYTES(POOL_BYTES)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (pctl_we_i),
    .sw_wdata_i  (pctl_wdata_i),
    .hw_we_i     (cnt_we),
    .hw_cnt_i    (cnt),
    .page_mode_i (page_mode_i),
    .page_i      (page_i),
    .pctl_o      (pctl_o),
    .base_o      (base),
    .tx_last_o   (tx_last),
    .rx_last_o   (rx_last)
  );

  ipool_ram #(.POOL_BYTES(POOL_BYTES)) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_size_i  (cpu_size_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_rdata_o (cpu_rdata_o),
    .eng_addr_i  (pool_addr),
    .eng_rdata_o (pool_rdata),
    .eng_we_i    (pool_we),
    .eng_wdata_i (pool_wdata)
  );

  ipool_seq #(.POOL_BYTES(POOL_BYTES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd),
    .sram_en_i    (sram_en_i),
    .base_i       (base),
    .tx_last_i    (tx_last),
    .rx_last_i    (rx_last),
    .pool_rdata_i (pool_rdata),
    .pool_addr_o  (pool_addr),
    .pool_we_o    (pool_we),
    .pool_wdata_o (pool_wdata),
    .cnt_we_o     (cnt_we),
    .cnt_o        (cnt),
    .link_req_o   (link_req_o),
    .link_start_o (link_start_o),
    .link_op_o    (link_op_o),
    .link_last_o  (link_last_o),
    .link_data_o  (link_data_o),
    .link_done_i  (link_done_i),
    .link_ack_i   (link_ack_i),
    .link_data_i  (link_data_i),
    .busy_o       (busy_o),
    .buf_en_o     (buf_en_o),
    .done_o       (done_o),
    .done_ack_o   (done_ack_o)
  );

endmodule

// File: rtl/ipool_chk.sv
module ipool_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sram_en_i,
  input logic        cmd_valid_i,
  input logic [7:0]  cmd_i,
  input logic        busy_o,
  input logic [1:0]  buf_en_o,
  input logic        done_o,
  input logic        done_ack_o,
  input logic [31:0] pctl_o,
  input logic        link_req_o,
  input logic        link_start_o,
  input logic        link_op_o,
  input logic        link_done_i
);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_ack_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ack_o |-> done_o);

  a_r8_bufs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (buf_en_o == 2'b00));

  a_r9_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && !sram_en_i && (|cmd_i[7:4])) |=> !busy_o);

  a_r1_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(pctl_o[31:24]));

  a_r4_start_is_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_start_o |-> (link_req_o && !link_op_o));

  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && !link_done_i) |=> (link_req_o && $stable(link_start_o) && $stable(link_op_o)));

  a_r8_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !link_req_o);

endmodule

bind i2c_pool_engine ipool_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sram_en_i    (sram_en_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .busy_o       (busy_o),
  .buf_en_o     (buf_en_o),
  .done_o       (done_o),
  .done_ack_o   (done_ack_o),
  .pctl_o       (pctl_o),
  .link_req_o   (link_req_o),
  .link_start_o (link_start_o),
  .link_op_o    (link_op_o),
  .link_done_i  (link_done_i)
);

// File: tb/sim_i2c_pool_engine.sv
module sim_i2c_pool_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 1024;
  localparam int AW = 10;

  localparam logic [7:0] C_START = 8'h01, C_TX = 8'h02, C_RX = 8'h04, C_LAST = 8'h08;
  localparam logic [7:0] C_TXB = 8'h10, C_RXB = 8'h20, C_TXD = 8'h40, C_RXD = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sram_en = 1'b1, page_mode = 1'b0;
  logic [2:0] page = '0;
  logic pctl_we = 1'b0;
  logic [31:0] pctl_wdata = '0, pctl;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0] cpu_size = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd = '0;
  logic busy, done, done_ack;
  logic [1:0] buf_en;
  logic link_req, link_start, link_op, link_last;
  logic [7:0] link_data;
  logic link_done = 1'b0, link_ack = 1'b0;
  logic [7:0] link_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_pool_engine #(.POOL_BYTES(PB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sram_en_i(sram_en), .page_mode_i(page_mode), .page_i(page),
    .pctl_we_i(pctl_we), .pctl_wdata_i(pctl_wdata), .pctl_o(pctl),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_size_i(cpu_size),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .busy_o(busy), .buf_en_o(buf_en),
    .done_o(done), .done_ack_o(done_ack),
    .link_req_o(link_req), .link_start_o(link_start), .link_op_o(link_op),
    .link_last_o(link_last), .link_data_o(link_data),
    .link_done_i(link_done), .link_ack_i(link_ack), .link_data_i(link_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_pool [PB];
  logic [7:0] exp_cnt = '0;

  // link model state
  int nak_at = -1, n_sent = 0, n_rcv = 0, xfer_id = 0;
  logic [7:0] sent_b [0:511];
  logic sent_s [0:511];
  logic rlast [0:511];
  logic [1:0] bufen_tx, bufen_rx;

  function automatic logic [7:0] rx_byte(int id, int k);
    return 8'((k * 37) + (id * 11) + 5);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (link_req && !link_done) begin
        logic a;
        logic [7:0] d;
        a = 1'b1;
        d = 8'h00;
        if (!link_op) begin
          if (n_sent == 0) bufen_tx = buf_en;
          sent_b[n_sent] = link_data;
          sent_s[n_sent] = link_start;
          a = (n_sent != nak_at);
          n_sent++;
        end else begin
          if (n_rcv == 0) bufen_rx = buf_en;
          d = rx_byte(xfer_id, n_rcv);
          rlast[n_rcv] = link_last;
          n_rcv++;
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        link_done = 1'b1;
        link_ack = a;
        link_rdata = d;
        @(negedge clk);
        link_done = 1'b0;
      end
    end
  end

  task automatic cpu_wr(int addr, int size, logic [31:0] data);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(addr); cpu_size = 2'(size); cpu_wdata = data;
    for (int b = 0; b <= size; b++) ref_pool[(addr + b) % PB] = data[8*b +: 8];
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(int addr, int size, output logic [31:0] data);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(addr); cpu_size = 2'(size);
    @(negedge clk);
    data = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  function automatic logic [31:0] rd_exp(int addr, int size);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b <= size; b++) v[8*b +: 8] = ref_pool[(addr + b) % PB];
    return v;
  endfunction

  task automatic pctl_wr(logic [31:0] v);
    pctl_we = 1'b1; pctl_wdata = v;
    @(negedge clk);
    pctl_we = 1'b0;
  endtask

  task automatic run(logic [7:0] c, bit pm, int pg, int off, int txl, int rxl, int nakpos, string tag);
    int base, ne, t, exp_nr;
    logic [7:0] eb [0:511];
    bit es [0:511];
    bit exp_ack, got_done, got_ack, seq_ok, rx_ok, last_ok;
    logic [31:0] rv;
    page_mode = pm; page = 3'(pg);
    pctl_wr({8'h00, 8'(rxl), 8'(txl), 2'b00, 6'(off)});
    base = ((pm ? pg * 256 : 0) + off * 4) % PB;
    ne = 0;
    if ((c & C_START) != 0 && (c & C_TXB) != 0) begin
      eb[ne] = ref_pool[base]; es[ne] = 1'b1; ne++;
      if ((c & C_TX) != 0)
        for (int i = 1; i <= txl; i++) begin eb[ne] = ref_pool[(base + i) % PB]; es[ne] = 1'b0; ne++; end
    end else if ((c & C_TX) != 0 && (c & C_TXB) != 0) begin
      for (int i = 0; i <= txl; i++) begin eb[ne] = ref_pool[(base + i) % PB]; es[ne] = 1'b0; ne++; end
    end
    exp_ack = !(nakpos >= 0 && nakpos < ne);
    if (!exp_ack) ne = nakpos + 1;
    exp_nr = (exp_ack && (c & C_RX) != 0 && (c & C_RXB) != 0) ? rxl + 1 : 0;

    n_sent = 0; n_rcv = 0; nak_at = nakpos; xfer_id++;
    bufen_tx = 2'b00; bufen_rx = 2'b00;
    cmd_valid = 1'b1; cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = '0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    got_done = done; got_ack = done_ack;
    @(negedge clk);
    check(got_done, "R10 done pulse", 64'(got_done), 64'd1);
    check(got_ack == exp_ack, "R10 ack flag", 64'(got_ack), 64'(exp_ack));
    seq_ok = (n_sent == ne);
    for (int i = 0; i < ne && i < n_sent; i++)
      if (sent_b[i] !== eb[i] || sent_s[i] !== es[i]) seq_ok = 1'b0;
    check(seq_ok, tag, 64'(n_sent), 64'(ne));
    check(buf_en == 2'b00, "R8 cleared after done", 64'(buf_en), 64'd0);
    if (ne > 0) check(bufen_tx == {((c & C_RXB) != 0), 1'b1}, "R8 during tx",
                      64'(bufen_tx), 64'({((c & C_RXB) != 0), 1'b1}));
    check(n_rcv == exp_nr, "R7 receive count", 64'(n_rcv), 64'(exp_nr));
    if (exp_nr > 0) begin
      check(bufen_rx == 2'b10, "R8 during rx", 64'(bufen_rx), 64'd2);
      exp_cnt = 8'(exp_nr);
      rx_ok = 1'b1; last_ok = 1'b1;
      for (int i = 0; i < exp_nr; i++) begin
        ref_pool[(base + i) % PB] = rx_byte(xfer_id, i);
        cpu_rd((base + i) % PB, 0, rv);
        if (rv !== {24'h0, rx_byte(xfer_id, i)}) rx_ok = 1'b0;
        if (rlast[i] !== (((c & C_LAST) != 0) && i == exp_nr - 1)) last_ok = 1'b0;
      end
      check(rx_ok, "R7 stored bytes", 64'(rx_ok), 64'd1);
      check(last_ok, "R7 last flag", 64'(last_ok), 64'd1);
    end
    check(pctl[31:24] == exp_cnt, "R1 R7 count field", 64'(pctl[31:24]), 64'(exp_cnt));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(pctl == 32'h0, "R1 reset", 64'(pctl), 64'd0);
    check(!busy && !done && !link_req && buf_en == 2'b00, "R10 reset idle",
          64'({busy, done, link_req, buf_en}), 64'd0);
    for (int a = 0; a < PB; a += 4) cpu_wr(a, 3, $urandom());

    // R1 software write keeps the hardware byte
    pctl_wr(32'hFFFF_FFFF);
    check(pctl == 32'h00FF_FFFF, "R1 sw write mask", 64'(pctl), 64'h00FF_FFFF);

    // R2 byte-lane access
    cpu_wr(100, 3, 32'hA1B2_C3D4);
    cpu_rd(100, 3, rv); check(rv == 32'hA1B2_C3D4, "R2 word", 64'(rv), 64'hA1B2_C3D4);
    cpu_rd(101, 0, rv); check(rv == 32'h0000_00C3, "R2 single byte", 64'(rv), 64'hC3);
    cpu_wr(201, 2, 32'hFF11_2233);
    cpu_rd(200, 3, rv); check(rv == rd_exp(200, 3), "R2 three-byte write", 64'(rv), 64'(rd_exp(200, 3)));
    cpu_wr(1023, 1, 32'h0000_5566);
    cpu_rd(1022, 3, rv); check(rv == rd_exp(1022, 3), "R2 wrap", 64'(rv), 64'(rd_exp(1022, 3)));
    cpu_rd(1022, 1, rv); check(rv == rd_exp(1022, 1), "R2 upper lanes zero", 64'(rv), 64'(rd_exp(1022, 1)));

    // directed transfers
    run(C_START | C_TX | C_TXB, 0, 0, 3, 0, 0, -1, "R4 address only");
    run(C_START | C_TX | C_TXB, 0, 0, 10, 5, 0, -1, "R4 address plus data");
    run(C_START | C_TXB, 0, 0, 12, 5, 0, -1, "R4 no tx bit");
    run(C_TX | C_TXB, 0, 0, 20, 6, 0, -1, "R5 data only");
    run(C_START | C_TX | C_TXB | C_RX | C_RXB, 0, 0, 7, 4, 3, 0, "R6 nak on address");
    run(C_START | C_TX | C_TXB, 0, 0, 7, 8, 0, 3, "R6 nak mid data");
    run(C_START | C_TX | C_TXB, 1, 3, 5, 3, 0, -1, "R3 paged window");
    run(C_START | C_TX | C_TXB, 1, 7, 63, 7, 0, -1, "R3 paged wrap");
    run(C_RX | C_RXB | C_LAST, 0, 0, 62, 0, 5, -1, "R7 rx only");
    run(C_START | C_TX | C_TXB | C_RX | C_RXB | C_LAST, 0, 0, 1, 2, 255, -1, "R7 rx 256 bytes");
    run(C_START | C_TX | C_TXB | C_RX | C_RXB, 1, 2, 40, 1, 9, -1, "R8 both phases");

    // R9 refusal with memory disabled
    sram_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      bit saw;
      n_sent = 0; n_rcv = 0;
      cmd_valid = 1'b1;
      cmd = (k == 0) ? (C_START | C_TX | C_TXB) : (C_RX | C_RXB | C_RXD);
      @(negedge clk);
      cmd_valid = 1'b0; cmd = '0;
      saw = 1'b0;
      repeat (20) begin
        if (busy || done || link_req || buf_en != 2'b00) saw = 1'b1;
        @(negedge clk);
      end
      check(!saw && n_sent == 0 && n_rcv == 0, "R9 refused", 64'(saw), 64'd0);
    end
    sram_en = 1'b1;

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] c;
      int m, np, tl;
      m = $urandom_range(0, 3);
      case (m)
        0: c = C_START | C_TX | C_TXB;
        1: c = C_TX | C_TXB;
        2: c = C_RX | C_RXB | (($urandom_range(0, 1) != 0) ? C_LAST : 8'h00);
        default: c = C_START | C_TX | C_TXB | C_RX | C_RXB | C_LAST;
      endcase
      tl = $urandom_range(0, 15);
      np = ($urandom_range(0, 3) == 0) ? $urandom_range(0, tl + 1) : -1;
      run(c, $urandom_range(0, 1) != 0, $urandom_range(0, 7), $urandom_range(0, 63),
          tl, $urandom_range(0, 15), np, (m == 1) ? "R5 random" : "R4 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule